// File: doc/BRIEF.md
# Pad Pull Resistor Latch Sequencer

This block sets the pull-up or pull-down state of every pad through a timed two-step handshake on a simple write bus. Software first writes a 2-bit pull code into a control register. It then sets, in one of the clock words, the bits of the pins that should take that code, and later writes that word back to zero. The block measures with cycle counters whether the code stayed untouched long enough before the clock bits rose. It also checks that the clock bits stayed up long enough. Only when both windows are met does each selected pin copy the code into its own state flop.

The per-pin state drives the pad pull controls directly and is kept until the next complete handshake or reset. Nothing in the block can be read back over the bus. Software therefore relies on following the timing; a handshake that breaks a window leaves the pins as they were.

Top module: `pull_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, every pin's pull state is 0 (none) and no clock bit is set.
- R2: Pin p's state is the 2-bit field pullState[2p+1:2p], coded 0 = none, 1 = pull-down, 2 = pull-up. The pull code is written at byte address 0x94, data bits [1:0]. After a complete handshake, each selected pin holds exactly the code that was written.
- R3: Pin p is selected by bit p mod 32 of the clock word at byte address 0x98 + 4*(p/32). Pins whose clock bit is zero keep their state.
- R4: A pin latches only if at least SETUP_CYCLES cycles with no control write pass between the control write (or reset) and the clock-word write. With fewer, the pin is unchanged.
- R5: The latch happens on the HOLD_CYCLES-th clock edge after the edge that wrote the clock word, provided that word is not written again before then. A clear written with fewer than HOLD_CYCLES idle cycles after the set leaves the pins unchanged.
- R6: Clearing the clock word, or writing a new control code with no clock bit set, leaves every latched state unchanged.
- R7: Code 3 is reserved. A handshake that uses it leaves the selected pins unchanged, and no pin ever holds 3.
- R8: A control write while clock bits are up cancels the pending latch for those bits.
- R9: Writes to any other address have no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 32 | Write data |
| pullState | output | 2*NUM_PINS | Latched 2-bit pull code per pin, pin p at bits [2p+1:2p] |

## Verification
The setup and hold counters and the per-word arm flags have no readback path. A fault in them shows only as a pin that changes when it should not, or stays put when it should change. Such a fault appears exactly HOLD_CYCLES edges after a clock-word write, or never. The bench therefore sweeps both timing windows at one cycle short of the limit and exactly at the limit. It compares the whole pullState vector after each handshake, so that a stray latch on an unselected pin is caught as well. It also probes the state one cycle before and on the expected latch edge, which exposes an off-by-one in either counter at once.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;
  localparam int WORD_BITS  = 32;
  localparam int WORD_SEL_W = 4;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_e;

  // strobes from the control half to the storage half
  typedef struct packed {
    logic                  ctrlWr;
    logic                  clkWr;
    logic [WORD_SEL_W-1:0] wordSel;
  } strobe_t;
endpackage

// File: rtl/pull_seq_ctrl.sv
module pull_seq_ctrl
  import pull_seq_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h94,
  parameter logic [ADDR_W-1:0] CLK_BASE = 'h98,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES = 150
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  output strobe_t              strobe,
  output logic [NUM_WORDS-1:0] latchWord
);
  localparam int SW = $clog2(SETUP_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (wrAddr == CTRL_ADDR) strobe.ctrlWr = 1'b1;
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (wrAddr == ADDR_W'(CLK_BASE + ADDR_W'(4 * w))) begin
          strobe.clkWr   = 1'b1;
          strobe.wordSel = WORD_SEL_W'(w);
        end
      end
    end
  end

  // idle cycles since the last control write, saturating
  logic [SW-1:0] setupCnt;
  logic          setupOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                setupCnt <= '0;
    else if (strobe.ctrlWr)                   setupCnt <= '0;
    else if (setupCnt != SW'(SETUP_CYCLES))   setupCnt <= setupCnt + 1'b1;
  end

  assign setupOk = (setupCnt == SW'(SETUP_CYCLES));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [HW-1:0] holdCnt;
    logic          armed;
    logic          wordHit;

    assign wordHit = strobe.clkWr && (strobe.wordSel == WORD_SEL_W'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCnt <= '0;
        armed   <= 1'b0;
      end else if (wordHit) begin
        holdCnt <= '0;
        armed   <= setupOk;
      end else begin
        if (strobe.ctrlWr) armed <= 1'b0;
        if (holdCnt != HW'(HOLD_CYCLES)) holdCnt <= holdCnt + 1'b1;
      end
    end

    assign latchWord[w] = armed && !wordHit && !strobe.ctrlWr &&
                          (holdCnt == HW'(HOLD_CYCLES - 1));
  end
endmodule

// File: rtl/pull_seq_data.sv
module pull_seq_data
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int NUM_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [NUM_WORDS-1:0]    latchWord,
  input  logic [WORD_BITS-1:0]    wrData,
  output logic [2*NUM_PINS-1:0]   pullState
);
  logic [1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlReg <= PULL_NONE;
    else if (strobe.ctrlWr) ctrlReg <= wrData[1:0];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / WORD_BITS;
    localparam int BITP = p % WORD_BITS;
    logic       clkBit;
    logic [1:0] pinState;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkBit   <= 1'b0;
        pinState <= PULL_NONE;
      end else begin
        if (strobe.clkWr && strobe.wordSel == WORD_SEL_W'(WORD))
          clkBit <= wrData[BITP];
        if (latchWord[WORD] && clkBit && ctrlReg != PULL_RSVD)
          pinState <= ctrlReg;
      end
    end

    assign pullState[2*p +: 2] = pinState;
  end
endmodule

// File: rtl/pull_seq.sv
module pull_seq
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h94,
  parameter logic [ADDR_W-1:0] CLK_BASE = 'h98,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES = 150
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [31:0]           wrData,
  output logic [2*NUM_PINS-1:0] pullState
);
  localparam int NUM_WORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS;

  strobe_t              strobe;
  logic [NUM_WORDS-1:0] latchWord;

  pull_seq_ctrl #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .CLK_BASE(CLK_BASE), .SETUP_CYCLES(SETUP_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .strobe(strobe), .latchWord(latchWord)
  );

  pull_seq_data #(
    .NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .latchWord(latchWord),
    .wrData(wrData), .pullState(pullState)
  );
endmodule

// File: rtl/pull_seq_chk.sv
module pull_seq_chk #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h94,
  parameter logic [ADDR_W-1:0] CLK_BASE = 'h98,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES = 150
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [2*NUM_PINS-1:0] pullState
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int AGE_MAX = SETUP_CYCLES + HOLD_CYCLES + 1;

  int ctrlAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   ctrlAge <= 0;
    else if (wrEn && wrAddr == CTRL_ADDR)        ctrlAge <= 0;
    else if (ctrlAge < AGE_MAX)                  ctrlAge <= ctrlAge + 1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> pullState == '0);

  // R4
  setup_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pullState) |-> ctrlAge > SETUP_CYCLES + HOLD_CYCLES);

  // R8
  ctrl_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == CTRL_ADDR) |=> $stable(pullState));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wchk
    localparam int LO = w * 32;
    localparam int CNT = (NUM_PINS - LO < 32) ? (NUM_PINS - LO) : 32;
    // R5
    hold_rewrite_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(CLK_BASE + ADDR_W'(4 * w)))
      |=> $stable(pullState[2*LO +: 2*CNT]));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pchk
    // R7
    no_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
      pullState[2*p +: 2] != 2'd3);
  end
endmodule

bind pull_seq pull_seq_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .CLK_BASE(CLK_BASE), .SETUP_CYCLES(SETUP_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .pullState(pullState)
);

// File: tb/pull_seq_tb.sv
module pull_seq_tb;
  localparam int PINS  = 40;
  localparam int SETUP = 6;
  localparam int HOLD  = 4;
  localparam logic [7:0] CTRL_A = 8'h94;
  localparam logic [7:0] CLK_A  = 8'h98;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2*PINS-1:0] pullState;

  always #5 clk = ~clk;

  pull_seq #(.NUM_PINS(PINS), .SETUP_CYCLES(SETUP), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pullState(pullState)
  );

  logic [1:0] expState [PINS];
  int checks = 0;
  int errors = 0;

  function automatic logic [2*PINS-1:0] packExp();
    logic [2*PINS-1:0] v;
    for (int p = 0; p < PINS; p++) v[2*p +: 2] = expState[p];
    return v;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (pullState !== packExp()) begin
      errors++;
      $display("FAIL %s: pullState got %h expected %h", tag, pullState, packExp());
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runSeq(input int val, input int word, input logic [31:0] mask,
                        input int sIdle, input int hIdle);
    busWrite(CTRL_A, 32'(val));
    idle(sIdle);
    busWrite(CLK_A + 8'(4 * word), mask);
    idle(hIdle);
    busWrite(CLK_A + 8'(4 * word), 32'h0);
    idle(2);
    if (sIdle >= SETUP && hIdle >= HOLD && val != 3)
      for (int p = 0; p < PINS; p++)
        if (p / 32 == word && mask[p % 32]) expState[p] = 2'(val);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < PINS; p++) expState[p] = 2'd0;
    idle(3);
    check("R1 during reset");
    rstN = 1'b1;
    idle(1);
    check("R1 after release");

    // sweep code, setup gap, hold gap and word
    for (int v = 0; v < 4; v++)
      for (int s = 0; s < 3; s++)
        for (int h = 0; h < 2; h++)
          for (int w = 0; w < 2; w++) begin
            int sI = (s == 0) ? SETUP - 1 : (s == 1) ? SETUP : SETUP + 3;
            int hI = (h == 0) ? HOLD - 1 : HOLD;
            int rot = v * 5 + s * 3 + h * 7 + w;
            logic [31:0] m = (32'hA5C3_1E69 << rot) | (32'hA5C3_1E69 >> (32 - rot));
            runSeq(v, w, m, sI, hI);
            if (sI < SETUP) check("R4 short setup");
            else if (hI < HOLD) check("R5 short hold");
            else if (v == 3) check("R7 reserved code");
            else check("R2 full handshake");
          end

    // walk every pin on its own
    for (int p = 0; p < PINS; p++) begin
      runSeq((p % 3) ^ 1, p / 32, 32'(1) << (p % 32), SETUP, HOLD);
      check("R3 single pin select");
    end

    // latch edge position
    busWrite(CTRL_A, 32'd1);
    idle(SETUP);
    busWrite(CLK_A, 32'h0000_0F00);
    idle(HOLD - 1);
    check("R5 one cycle before latch");
    idle(1);
    for (int p = 8; p < 12; p++) expState[p] = 2'd1;
    check("R5 on latch edge");
    busWrite(CLK_A, 32'h0);
    idle(2);

    // retention under a new code with no clock bit set
    busWrite(CTRL_A, 32'd2);
    idle(SETUP + HOLD + 5);
    check("R6 retention");

    // control write during hold cancels
    busWrite(CTRL_A, 32'd1);
    idle(SETUP);
    busWrite(CLK_A, 32'h0000_00F0);
    idle(1);
    busWrite(CTRL_A, 32'd2);
    idle(HOLD + 3);
    check("R8 cancel while held");
    busWrite(CLK_A, 32'h0);
    idle(2);
    check("R8 after clear");

    // other addresses
    busWrite(CTRL_A, 32'd2);
    idle(SETUP);
    busWrite(8'hA0, 32'hFFFF_FFFF);
    busWrite(8'h90, 32'hFFFF_FFFF);
    busWrite(8'h95, 32'hFFFF_FFFF);
    idle(HOLD + 2);
    check("R9 foreign addresses");

    // reset mid run
    rstN = 1'b0;
    idle(1);
    for (int p = 0; p < PINS; p++) expState[p] = 2'd0;
    check("R1 mid-run reset");
    rstN = 1'b1;
    idle(1);
    runSeq(0, 0, 32'hFFFF_FFFF, SETUP, HOLD);
    check("R1 clock bits cleared by reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule